// File: doc/BRIEF.md
# Double-Buffered Timer Status Flags

This block holds the status flags of a small two-channel timer/counter whose period and channel registers are double-buffered. Software writes new values into buffer registers. A buffered value moves into its active register only on an update event, which is a counter wrap while the update lock is released. Each buffer has a valid flag. In compare mode the flag marks a buffered value that is waiting for an update. In capture mode it marks a captured count that software has not yet read. The block also keeps a stop flag, which combines the enable level, the stop and retrigger commands and one-shot wraps. It keeps a slave flag as well, for chained 32-bit operation.

All status bits are read through one 8-bit status word. Every input is a single-cycle strobe or a level, so there is no streaming handshake and no back-pressure: an event is taken in the cycle its strobe is high. A simple up/down counter inside the block wraps at the active period and produces the wrap events.

Top module: `tmr_dbuf_status`

## Requirements
- R1: After reset the status word reads 0x01 (stopped), the count is 0 and the active period is all ones.
- R2: Status layout: bit 0 stop, bit 1 slave, bit 3 period buffer valid, bits 4 and 5 channel 0 and channel 1 buffer valid. Bits 2, 6 and 7 always read 0, and writes to them have no effect.
- R3: With a channel in compare mode (ch_capture bit 0), a write strobe to its buffer stores wr_data and sets its valid bit in the next cycle.
- R4: An update copies every valid buffer into its active register and clears those compare and period valid bits in the same cycle.
- R5: A status write with a 1 in a valid bit position clears that bit only while lock_upd is high. With lock_upd low it has no effect, and a 0 in a position never changes anything. The stop bit cannot be written.
- R6: With a channel in capture mode (ch_capture bit 1), a capture strobe stores the present count into the buffer and sets the valid bit. The bit survives updates and is cleared by a read strobe of that channel.
- R7: The period valid bit works only in 8-bit mode (cnt_mode 0). In 16-bit (1) and 32-bit (2) modes it reads 0, and a period write goes straight to the active period.
- R8: The stop bit becomes 1 in the cycle after a stop command, or after enable is sampled low. While stopped, the count holds.
- R9: With oneshot high, a wrap sets the stop bit. The counter stops holding its wrapped value: 0 counting up, the period counting down.
- R10: The stop bit clears after a rising edge of enable, or after a retrigger command while stopped and enabled. A retrigger reloads the count with 0 when counting up and with the period when counting down.
- R11: The slave bit is 1 in the cycle after chain_master_32 is high in 32-bit mode, and 0 otherwise.
- R12: When a set and a clear reach one valid flag in the same cycle, the flag ends up set.
- R13: Counting up, the count goes from the period to 0. Counting down, it goes from 0 to the period. That step is a wrap, and a wrap with lock_upd low is an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_mode | input | 2 | Counter mode: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| chain_master_32 | input | 1 | Paired master is configured for 32-bit operation |
| ch_capture | input | NCH | Per channel: 1 = capture mode, 0 = compare mode |
| enable | input | 1 | Counter enable level |
| dir_down | input | 1 | 1 = count down |
| oneshot | input | 1 | Stop on the next wrap |
| cmd_stop | input | 1 | Stop command strobe |
| cmd_retrigger | input | 1 | Retrigger command strobe |
| lock_upd | input | 1 | Blocks updates; allows write-one-to-clear of valid bits |
| wr_per_buf | input | 1 | Period buffer write strobe |
| wr_cc_buf | input | NCH | Channel buffer write strobes |
| wr_data | input | W | Data for buffer writes |
| cap_evt | input | NCH | Capture strobes |
| rd_cc | input | NCH | Channel register read strobes |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 8 | Status write data (write one to clear) |
| stat_rdata | output | 8 | Status word |
| count | output | W | Counter value |
| per_act | output | W | Active period |
| cc_buf | output | NCH*W | Channel buffers, channel 0 in the low bits |
| cc_act | output | NCH*W | Active channel registers, channel 0 in the low bits |

## Verification
A valid flag in the wrong state shows up at the ports in one of two ways. If it is wrongly clear, the active register does not change at the next wrap. If it is wrongly set, the active register changes when it should not, or the status word misreports. Either way the error is visible within one period. A stop flag in the wrong state shows in the next cycle, because the count either holds or keeps moving. The bench sweeps the count through whole periods in both directions and predicts each next value arithmetically. It also drives every set and clear path of every flag, including the collisions where a set and a clear arrive together.

// File: rtl/tmr_stat_pkg.sv
package tmr_stat_pkg;
  typedef enum logic [1:0] {
    CM_8  = 2'd0,
    CM_16 = 2'd1,
    CM_32 = 2'd2
  } cnt_mode_e;

  localparam int unsigned ST_W     = 8;
  localparam int unsigned ST_STOP  = 0;
  localparam int unsigned ST_SLAVE = 1;
  localparam int unsigned ST_PBUF  = 3;
  localparam int unsigned ST_CBUF0 = 4;
endpackage

// File: rtl/tmr_buf_slot.sv
module tmr_buf_slot #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_mode,
  input  logic         direct,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         cap,
  input  logic [W-1:0] cap_val,
  input  logic         rd,
  input  logic         w1c,
  input  logic         upd,
  output logic [W-1:0] buf_q,
  output logic [W-1:0] act_q,
  output logic         valid
);
  logic set_ev, clr_ev;

  // compare and capture use different set/clear sources
  assign set_ev = cap_mode ? cap : (wr & ~direct);
  assign clr_ev = cap_mode ? rd  : (upd | w1c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
    end else if (set_ev) begin
      valid <= 1'b1;                 // set wins over clear
    end else if (clr_ev) begin
      valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= RST_VAL;
    end else if (cap_mode && cap) begin
      buf_q <= cap_val;
    end else if (!cap_mode && wr) begin
      buf_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= RST_VAL;
    end else if (!cap_mode && wr && direct) begin
      act_q <= wdata;
    end else if (!cap_mode && upd && valid) begin
      act_q <= buf_q;
    end
  end

  assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> valid);

  assert_cap_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode && rd && !cap) |=> !valid);

  assert_upd_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_mode && upd && valid && !(wr && direct)) |=> (act_q == $past(buf_q)));
endmodule

// File: rtl/tmr_cnt_core.sv
module tmr_cnt_core #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         down,
  input  logic         retrig,
  input  logic [W-1:0] per,
  output logic [W-1:0] count,
  output logic         ovf
);
  logic [W-1:0] reload;

  assign reload = down ? per : '0;
  assign ovf    = run && (down ? (count == '0) : (count == per));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (retrig) begin
      count <= reload;
    end else if (run) begin
      if (ovf)       count <= reload;
      else if (down) count <= count - 1'b1;
      else           count <= count + 1'b1;
    end
  end

  assert_wrap_up_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !down && !retrig) |=> (count == '0));

  assert_hold_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !retrig) |=> $stable(count));
endmodule

// File: rtl/tmr_run_ctl.sv
module tmr_run_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic cmd_stop,
  input  logic cmd_retrigger,
  input  logic ovf,
  input  logic oneshot,
  input  logic chain32,
  output logic stop_q,
  output logic slave_q,
  output logic run,
  output logic retrig
);
  logic en_q, stop_set, stop_clr;

  assign retrig   = cmd_retrigger & enable;
  assign stop_set = ~enable | cmd_stop | (ovf & oneshot);
  assign stop_clr = (enable & ~en_q) | (retrig & stop_q);
  assign run      = enable & ~stop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      stop_q  <= 1'b1;
      slave_q <= 1'b0;
    end else begin
      en_q    <= enable;
      slave_q <= chain32;
      if (stop_set)      stop_q <= 1'b1;
      else if (stop_clr) stop_q <= 1'b0;
    end
  end

  assert_stop_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stop || !enable) |=> stop_q);

  assert_oneshot_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && oneshot) |=> stop_q);

  assert_retrig_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (retrig && stop_q && !cmd_stop && !(ovf && oneshot)) |=> !stop_q);
endmodule

// File: rtl/tmr_dbuf_status.sv
module tmr_dbuf_status
  import tmr_stat_pkg::*;
#(
  parameter int unsigned W   = 8,
  parameter int unsigned NCH = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cnt_mode,
  input  logic               chain_master_32,
  input  logic [NCH-1:0]     ch_capture,
  input  logic               enable,
  input  logic               dir_down,
  input  logic               oneshot,
  input  logic               cmd_stop,
  input  logic               cmd_retrigger,
  input  logic               lock_upd,
  input  logic               wr_per_buf,
  input  logic [NCH-1:0]     wr_cc_buf,
  input  logic [W-1:0]       wr_data,
  input  logic [NCH-1:0]     cap_evt,
  input  logic [NCH-1:0]     rd_cc,
  input  logic               stat_wr,
  input  logic [ST_W-1:0]    stat_wdata,
  output logic [ST_W-1:0]    stat_rdata,
  output logic [W-1:0]       count,
  output logic [W-1:0]       per_act,
  output logic [NCH*W-1:0]   cc_buf,
  output logic [NCH*W-1:0]   cc_act
);
  localparam int unsigned CW = NCH * W;

  logic           mode8, chain32;
  logic           ovf, upd, run, retrig;
  logic           stop_q, slave_q;
  logic           pvalid, w1c_per;
  logic [W-1:0]   per_buf;
  logic [NCH-1:0] cvalid, w1c_cc;

  assign mode8   = (cnt_mode == CM_8);
  assign chain32 = (cnt_mode == CM_32) & chain_master_32;
  assign upd     = ovf & ~lock_upd;
  assign w1c_per = stat_wr & lock_upd & stat_wdata[ST_PBUF];

  tmr_run_ctl u_run (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .cmd_stop      (cmd_stop),
    .cmd_retrigger (cmd_retrigger),
    .ovf           (ovf),
    .oneshot       (oneshot),
    .chain32       (chain32),
    .stop_q        (stop_q),
    .slave_q       (slave_q),
    .run           (run),
    .retrig        (retrig)
  );

  tmr_cnt_core #(.W(W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .down   (dir_down),
    .retrig (retrig),
    .per    (per_act),
    .count  (count),
    .ovf    (ovf)
  );

  tmr_buf_slot #(.W(W), .RST_VAL({W{1'b1}})) u_per (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_mode (1'b0),
    .direct   (~mode8),
    .wr       (wr_per_buf),
    .wdata    (wr_data),
    .cap      (1'b0),
    .cap_val  ({W{1'b0}}),
    .rd       (1'b0),
    .w1c      (w1c_per),
    .upd      (upd),
    .buf_q    (per_buf),
    .act_q    (per_act),
    .valid    (pvalid)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign w1c_cc[g] = stat_wr & lock_upd & stat_wdata[ST_CBUF0 + g];

    tmr_buf_slot #(.W(W), .RST_VAL({W{1'b0}})) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_mode (ch_capture[g]),
      .direct   (1'b0),
      .wr       (wr_cc_buf[g]),
      .wdata    (wr_data),
      .cap      (cap_evt[g]),
      .cap_val  (count),
      .rd       (rd_cc[g]),
      .w1c      (w1c_cc[g]),
      .upd      (upd),
      .buf_q    (cc_buf[g*W +: W]),
      .act_q    (cc_act[g*W +: W]),
      .valid    (cvalid[g])
    );
  end

  always_comb begin
    stat_rdata           = '0;
    stat_rdata[ST_STOP]  = stop_q;
    stat_rdata[ST_SLAVE] = slave_q;
    stat_rdata[ST_PBUF]  = pvalid & mode8;
    for (int i = 0; i < NCH; i++) begin
      stat_rdata[ST_CBUF0 + i] = cvalid[i];
    end
  end

  assert_per_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && pvalid && mode8 && !wr_per_buf) |=> (per_act == $past(per_buf)));

  assert_lock_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_upd && (&ch_capture == 1'b0) && !(|wr_cc_buf)) |=> $stable(cc_act[CW-1:0]) || $past(|ch_capture));
endmodule

// File: tb/tb_tmr_dbuf_status.sv
`timescale 1ns/1ps
module tb_tmr_dbuf_status;
  localparam int W = 8;
  localparam int NCH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cnt_mode = 2'd0;
  logic chain_master_32 = 1'b0;
  logic [NCH-1:0] ch_capture = '0;
  logic enable = 1'b0, dir_down = 1'b0, oneshot = 1'b0;
  logic cmd_stop = 1'b0, cmd_retrigger = 1'b0, lock_upd = 1'b0;
  logic wr_per_buf = 1'b0;
  logic [NCH-1:0] wr_cc_buf = '0, cap_evt = '0, rd_cc = '0;
  logic [W-1:0] wr_data = '0;
  logic stat_wr = 1'b0;
  logic [7:0] stat_wdata = '0;
  logic [7:0] stat_rdata;
  logic [W-1:0] count, per_act;
  logic [NCH*W-1:0] cc_buf, cc_act;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr_dbuf_status #(.W(W), .NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_mode(cnt_mode), .chain_master_32(chain_master_32),
    .ch_capture(ch_capture), .enable(enable), .dir_down(dir_down), .oneshot(oneshot),
    .cmd_stop(cmd_stop), .cmd_retrigger(cmd_retrigger), .lock_upd(lock_upd),
    .wr_per_buf(wr_per_buf), .wr_cc_buf(wr_cc_buf), .wr_data(wr_data),
    .cap_evt(cap_evt), .rd_cc(rd_cc), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .stat_rdata(stat_rdata), .count(count), .per_act(per_act),
    .cc_buf(cc_buf), .cc_act(cc_act)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic swr(input logic [7:0] d);
    stat_wr = 1'b1; stat_wdata = d; step(); stat_wr = 1'b0; stat_wdata = '0;
  endtask

  task automatic bufwr(input int ch, input logic [W-1:0] d);
    wr_data = d;
    if (ch < 0) wr_per_buf = 1'b1; else wr_cc_buf[ch] = 1'b1;
    step();
    wr_per_buf = 1'b0; wr_cc_buf = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] c;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1", "status", stat_rdata, 8'h01);
    chk("R1", "count", count, 0);
    chk("R1", "per_act", per_act, 8'hFF);
    // R3 compare writes
    bufwr(0, 8'h33); chk("R3", "ch0 valid", stat_rdata, 8'h11);
    chk("R3", "ch0 buf", cc_buf[7:0], 8'h33);
    bufwr(1, 8'h44); chk("R3", "ch1 valid", stat_rdata, 8'h31);
    // R5 write-one-to-clear rules
    swr(8'h30); chk("R5", "w1c unlocked ignored", stat_rdata, 8'h31);
    lock_upd = 1'b1;
    swr(8'h00); chk("R5", "zero write ignored", stat_rdata, 8'h31);
    swr(8'hC4); chk("R2", "reserved write", stat_rdata, 8'h31);
    swr(8'h10); chk("R5", "w1c locked ch0", stat_rdata, 8'h21);
    // R12 set wins over w1c
    stat_wr = 1'b1; stat_wdata = 8'h20; wr_cc_buf = 2'b10; wr_data = 8'h45;
    step(); stat_wr = 1'b0; wr_cc_buf = '0;
    chk("R12", "write vs w1c", stat_rdata, 8'h21);
    swr(8'h21); chk("R5", "stop not writable", stat_rdata, 8'h01);
    // R7 period buffer in 8-bit mode
    bufwr(-1, 8'd4); chk("R7", "per valid 8-bit", stat_rdata, 8'h09);
    chk("R7", "per_act unchanged", per_act, 8'hFF);
    bufwr(0, 8'd2); bufwr(1, 8'd3);
    lock_upd = 1'b0; enable = 1'b1; step();
    chk("R10", "enable clears stop", stat_rdata, 8'h38);
    // R4 update at first wrap
    for (int k = 0; k < 600 && stat_rdata[4]; k++) step();
    chk("R4", "flags cleared", stat_rdata, 8'h00);
    chk("R4", "per copied", per_act, 8'd4);
    chk("R4", "cc copied", cc_act, 16'h0302);
    // R13 up sweep
    for (int k = 0; k < 15; k++) begin
      c = count; step();
      chk("R13", "up next", count, (c == 8'd4) ? 0 : c + 1);
    end
    // R5/R13 lock blocks update
    lock_upd = 1'b1; bufwr(0, 8'd7);
    repeat (12) step();
    chk("R13", "locked no copy", cc_act[7:0], 8'd2);
    chk("R5", "locked flag kept", stat_rdata[4], 1'b1);
    lock_upd = 1'b0; repeat (8) step();
    chk("R4", "unlocked copy", cc_act[7:0], 8'd7);
    chk("R4", "unlocked clear", stat_rdata[4], 1'b0);
    // R13 down sweep
    dir_down = 1'b1;
    for (int k = 0; k < 15; k++) begin
      c = count; step();
      chk("R13", "down next", count, (c == 0) ? 4 : c - 1);
    end
    // R9 one-shot
    oneshot = 1'b1;
    for (int k = 0; k < 20 && !stat_rdata[0]; k++) step();
    chk("R9", "oneshot stop", stat_rdata[0], 1'b1);
    chk("R9", "held at period", count, 8'd4);
    repeat (3) step();
    chk("R9", "still held", count, 8'd4);
    // R10 retrigger
    oneshot = 1'b0; cmd_retrigger = 1'b1; step(); cmd_retrigger = 1'b0;
    chk("R10", "retrigger runs", stat_rdata[0], 1'b0);
    chk("R10", "retrigger reload", count, 8'd4);
    // R8 stop command and disable
    cmd_stop = 1'b1; step(); cmd_stop = 1'b0;
    chk("R8", "stop cmd", stat_rdata[0], 1'b1);
    c = count; repeat (3) step();
    chk("R8", "count holds", count, c);
    cmd_retrigger = 1'b1; step(); cmd_retrigger = 1'b0;
    enable = 1'b0; step();
    chk("R8", "disable stops", stat_rdata[0], 1'b1);
    enable = 1'b1; dir_down = 1'b0; step();
    chk("R10", "re-enable", stat_rdata[0], 1'b0);
    // R6 capture
    ch_capture = 2'b11; step();
    c = count; cap_evt = 2'b01; step(); cap_evt = '0;
    chk("R6", "capture value", cc_buf[7:0], c);
    chk("R6", "capture valid", stat_rdata[4], 1'b1);
    repeat (10) step();
    chk("R6", "survives update", stat_rdata[4], 1'b1);
    rd_cc = 2'b01; step(); rd_cc = '0;
    chk("R6", "read clears", stat_rdata[4], 1'b0);
    cap_evt = 2'b10; rd_cc = 2'b10; step(); cap_evt = '0; rd_cc = '0;
    chk("R12", "capture vs read", stat_rdata[5], 1'b1);
    // R7 16-bit mode
    enable = 1'b0; ch_capture = '0; cnt_mode = 2'd1; step();
    bufwr(-1, 8'd9);
    chk("R7", "direct period", per_act, 8'd9);
    chk("R7", "per valid zero", stat_rdata[3], 1'b0);
    cnt_mode = 2'd0; bufwr(-1, 8'd6);
    chk("R7", "8-bit buffered", stat_rdata[3], 1'b1);
    chk("R7", "8-bit no direct", per_act, 8'd9);
    // R11 slave flag
    chain_master_32 = 1'b1; step();
    chk("R11", "slave needs 32-bit", stat_rdata[1], 1'b0);
    cnt_mode = 2'd2; step();
    chk("R11", "slave set", stat_rdata[1], 1'b1);
    chk("R2", "reserved zero", stat_rdata & 8'hC4, 8'h00);
    chain_master_32 = 1'b0; step();
    chk("R11", "slave clear", stat_rdata[1], 1'b0);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule